// File: doc/BRIEF.md
# Half-Duplex Buffered SPI Master

This block is a register-programmed SPI master that runs one half-duplex transaction at a time out of a buffer held in its own registers. Software writes a command word of up to four bytes and up to 32 data bytes. It then programs three separate bit counts, one each for the command, transmit and receive phases, and writes the start bit. The controller sends the command bits, then the transmit bits, and then clocks the receive bits into the same data buffer. Software can poll a busy flag for the whole transaction.

The register bus is a plain 32-bit interface with no wait states. A write takes effect on the clock edge where `bus_wr` is high, and `bus_rdata` follows `bus_addr` combinationally. There is no handshake and no back-pressure. Chip selects are driven only by software through a register, so one device can stay selected across several transactions. The SCLK rate comes from a divider that holds the ratio minus two. All four clock modes are available, and bit order within a byte can be MSB-first or LSB-first.

Register map (byte addresses): 0x00 control/status (write bit 8 = start, read bit 16 = busy); 0x04 command word; 0x08..0x24 data words 0..7; 0x28 configuration (bits 27:16 divider, bit 5 CPHA, bit 4 CPOL, bit 3 LSB-first); 0x2C phase lengths (bits 29:24 command bits, bits 23:12 receive bits, bits 11:0 transmit bits); 0x38 chip selects.

Top module: `spi_hd_master`

## Requirements
- R1: After reset, every register reads 0, busy is 0, all `spi_cs_n` lines are 1, `spi_sclk` is 0 and `spi_mosi` is 0.
- R2: Writing 1 to bit 8 at 0x00 while idle makes bit 16 at 0x00 read 1 from the next cycle until the transaction ends. A start written while busy is ignored and does not add a second transaction.
- R3: A transaction sends exactly the command bits, then the transmit bits, then clocks exactly the receive bits. Phases never go backwards. `spi_mosi` is 0 throughout the receive phase.
- R4: The command bit count is bits 29:24 of 0x2C, and values above 32 act as 32. The command word at 0x04 is right-aligned and goes out most-significant byte first, so the count 24 with word 0x00AABBCC sends AA, BB, CC.
- R5: The transmit bit count is bits 11:0 of 0x2C. Transmit bytes come from the data words in little-endian packing, with byte 0 in bits 7:0 of 0x08, byte 1 in bits 15:8, and so on.
- R6: The receive bit count is bits 23:12 of 0x2C. Received bytes overwrite the buffer in the same little-endian packing, starting at byte 0. Bits past the 256th are dropped, and buffer bytes the receive phase does not reach keep their values.
- R7: One SCLK period lasts (bits 27:16 of 0x28) + 2 system clocks. The first half of each bit lasts floor(ratio/2) clocks and the second half lasts the rest.
- R8: SCLK rests at CPOL (bit 4 of 0x28) when idle. With CPHA (bit 5) 0, MISO is sampled on the leading edge. With CPHA 1, MISO is sampled on the trailing edge. MOSI is stable at the sampling edge in all four modes.
- R9: Bit 3 of 0x28 set sends and receives each byte LSB-first; clear means MSB-first.
- R10: `spi_cs_n[i]` is the inverse of bit i at 0x38. It changes only on a write to 0x38 and never by itself around a transaction.
- R11: A start with all three counts zero completes without toggling SCLK. Busy reads 1 in the cycle after the start and 0 in the cycle after that.
- R12: Writes to the command, data, configuration and length registers are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| spi_sclk | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Several properties are checked on every cycle by the embedded properties. Busy follows a start. An empty start drops busy two cycles later. Phases only move forward. The bit index stays inside the current phase length. Chip selects and the command word hold unless a write is allowed to reach them. SCLK rests at CPOL whenever the controller is idle.

Other behaviours need a device model on the pins, so only the bench scenarios can show them. These are the byte order of the command and the data, the LSB-first option, the receive packing and the handling of a receive phase longer than the buffer. The measured SCLK period for even and odd ratios, and the behaviour in each clock mode, are also shown only by the bench.

// File: rtl/spi_hd_pkg.sv
`timescale 1ns/1ps
package spi_hd_pkg;
  localparam int ADDR_W     = 6;
  localparam int WORD_W     = 32;
  localparam int DATA_WORDS = 8;
  localparam int BUF_BITS   = DATA_WORDS * WORD_W;
  localparam int BIDX_W     = $clog2(BUF_BITS);
  localparam int CNT_W      = 12;
  localparam int CMD_CNT_W  = 6;
  localparam int CMD_MAX    = 32;
  localparam int DIV_W      = 12;
  localparam int RATIO_W    = DIV_W + 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA0 = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_LEN   = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_CS    = 6'h38;

  localparam int START_BIT = 8;
  localparam int BUSY_BIT  = 16;
  localparam int DIV_LSB   = 16;
  localparam int LSB_BIT   = 3;
  localparam int CPOL_BIT  = 4;
  localparam int CPHA_BIT  = 5;

  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_TX = 2'd1, PH_RX = 2'd2} phase_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             cpha;
    logic             cpol;
    logic             lsb;
  } cfg_t;

  // Packed layout matches the length register bits 29:0.
  typedef struct packed {
    logic [CMD_CNT_W-1:0] cmd_n;
    logic [CNT_W-1:0]     rx_n;
    logic [CNT_W-1:0]     tx_n;
  } lens_t;
endpackage

// File: rtl/spi_hd_regs.sv
`timescale 1ns/1ps
module spi_hd_regs
  import spi_hd_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                busy,
  input  logic                rx_we,
  input  logic [BIDX_W-1:0]   rx_addr,
  input  logic                rx_bit,
  output logic                start_o,
  output logic [WORD_W-1:0]   cmd_word,
  output logic [BUF_BITS-1:0] data_buf,
  output cfg_t                cfg,
  output lens_t               lens,
  output logic [NUM_CS-1:0]   cs_sel
);
  logic                  wr_ok;
  logic [DATA_WORDS-1:0] word_sel;
  logic [DATA_WORDS-1:0] word_hit;

  assign wr_ok   = bus_wr && !busy;
  assign start_o = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[START_BIT] && !busy;

  for (genvar w = 0; w < DATA_WORDS; w++) begin : g_wsel
    assign word_hit[w] = (bus_addr == OFS_DATA0 + ADDR_W'(4 * w));
    assign word_sel[w] = wr_ok && word_hit[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word <= '0;
      data_buf <= '0;
      cfg      <= '0;
      lens     <= '0;
      cs_sel   <= '0;
    end else begin
      if (wr_ok && bus_addr == OFS_CMD) cmd_word <= bus_wdata;
      if (wr_ok && bus_addr == OFS_CFG) begin
        cfg.div  <= bus_wdata[DIV_LSB +: DIV_W];
        cfg.cpha <= bus_wdata[CPHA_BIT];
        cfg.cpol <= bus_wdata[CPOL_BIT];
        cfg.lsb  <= bus_wdata[LSB_BIT];
      end
      if (wr_ok && bus_addr == OFS_LEN) lens <= lens_t'(bus_wdata[$bits(lens_t)-1:0]);
      if (bus_wr && bus_addr == OFS_CS) cs_sel <= bus_wdata[NUM_CS-1:0];
      for (int w = 0; w < DATA_WORDS; w++) begin
        if (word_sel[w]) data_buf[w*WORD_W +: WORD_W] <= bus_wdata;
      end
      if (rx_we) data_buf[rx_addr] <= rx_bit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CTRL) begin
      bus_rdata[BUSY_BIT] = busy;
    end else if (bus_addr == OFS_CMD) begin
      bus_rdata = cmd_word;
    end else if (bus_addr == OFS_CFG) begin
      bus_rdata[DIV_LSB +: DIV_W] = cfg.div;
      bus_rdata[CPHA_BIT]         = cfg.cpha;
      bus_rdata[CPOL_BIT]         = cfg.cpol;
      bus_rdata[LSB_BIT]          = cfg.lsb;
    end else if (bus_addr == OFS_LEN) begin
      bus_rdata[$bits(lens_t)-1:0] = lens;
    end else if (bus_addr == OFS_CS) begin
      bus_rdata[NUM_CS-1:0] = cs_sel;
    end
    for (int w = 0; w < DATA_WORDS; w++) begin
      if (word_hit[w]) bus_rdata = data_buf[w*WORD_W +: WORD_W];
    end
  end

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_CS) |=> $stable(cs_sel)); // R10

  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == OFS_CMD) |=> $stable(cmd_word)); // R12
endmodule

// File: rtl/spi_hd_halftimer.sv
`timescale 1ns/1ps
module spi_hd_halftimer
  import spi_hd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [RATIO_W-1:0] load_val,
  output logic               expire
);
  logic [RATIO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/spi_hd_txsel.sv
`timescale 1ns/1ps
module spi_hd_txsel
  import spi_hd_pkg::*;
(
  input  logic [WORD_W-1:0]    cmd_word,
  input  logic [BUF_BITS-1:0]  data_buf,
  input  phase_e               phase,
  input  logic [CNT_W-1:0]     bit_idx,
  input  logic [CMD_CNT_W-1:0] cmd_len,
  input  logic                 lsb,
  output logic                 tx_bit
);
  logic [2:0] pos;
  logic [2:0] nbytes;
  logic [2:0] cbyte;

  assign pos    = lsb ? bit_idx[2:0] : ~bit_idx[2:0];
  assign nbytes = 3'((cmd_len + CMD_CNT_W'(7)) >> 3);
  // Right-aligned command: the highest occupied byte leaves first.
  assign cbyte  = nbytes - 3'd1 - {1'b0, bit_idx[4:3]};

  always_comb begin
    if (phase == PH_CMD)                  tx_bit = cmd_word[{cbyte[1:0], pos}];
    else if (bit_idx < CNT_W'(BUF_BITS))  tx_bit = data_buf[{bit_idx[BIDX_W-1:3], pos}];
    else                                  tx_bit = 1'b0;
  end
endmodule

// File: rtl/spi_hd_engine.sv
`timescale 1ns/1ps
module spi_hd_engine
  import spi_hd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  cfg_t                 cfg,
  input  lens_t                lens,
  input  logic                 tx_bit,
  input  logic                 miso,
  output logic                 busy,
  output logic                 sclk,
  output logic                 mosi,
  output phase_e               phase,
  output logic [CNT_W-1:0]     bit_idx,
  output logic [CMD_CNT_W-1:0] cmd_len,
  output logic                 rx_we,
  output logic [BIDX_W-1:0]    rx_addr,
  output logic                 rx_bit
);
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} st_e;

  st_e              st_q;
  logic             half_q;
  phase_e           ph_q;
  logic [CNT_W-1:0] bit_q;

  logic [RATIO_W-1:0] ratio, h1, h2, tmr_val;
  logic [CNT_W-1:0]   plen;
  logic               has_work, has_next, last_bit, step, tmr_load, expire;
  phase_e             first_ph, next_ph;

  assign ratio   = RATIO_W'(cfg.div) + RATIO_W'(2);
  assign h1      = ratio >> 1;
  assign h2      = ratio - h1;
  assign cmd_len = (lens.cmd_n > CMD_CNT_W'(CMD_MAX)) ? CMD_CNT_W'(CMD_MAX) : lens.cmd_n;

  assign has_work = (cmd_len != '0) || (lens.tx_n != '0) || (lens.rx_n != '0);
  assign first_ph = (cmd_len != '0) ? PH_CMD : ((lens.tx_n != '0) ? PH_TX : PH_RX);
  assign has_next = ((ph_q == PH_CMD) && ((lens.tx_n != '0) || (lens.rx_n != '0))) ||
                    ((ph_q == PH_TX) && (lens.rx_n != '0));
  assign next_ph  = ((ph_q == PH_CMD) && (lens.tx_n != '0)) ? PH_TX : PH_RX;

  always_comb begin
    case (ph_q)
      PH_CMD:  plen = CNT_W'(cmd_len);
      PH_TX:   plen = lens.tx_n;
      default: plen = lens.rx_n;
    endcase
  end

  assign last_bit = (bit_q == plen - 1'b1);
  assign step     = (st_q == ST_SHIFT) && expire;
  assign tmr_load = ((st_q == ST_IDLE) && start && has_work) || step;
  assign tmr_val  = (step && !half_q) ? (h2 - 1'b1) : (h1 - 1'b1);

  spi_hd_halftimer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= 1'b0;
      ph_q   <= PH_CMD;
      bit_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          bit_q  <= '0;
          half_q <= 1'b0;
          ph_q   <= first_ph;
          st_q   <= has_work ? ST_SHIFT : ST_DONE;
        end
        ST_SHIFT: if (expire) begin
          if (!half_q) begin
            half_q <= 1'b1;
          end else begin
            half_q <= 1'b0;
            if (last_bit) begin
              bit_q <= '0;
              if (has_next) ph_q <= next_ph;
              else          st_q <= ST_DONE;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // First half of a bit sits at CPOL^CPHA; MISO is taken as it ends.
  assign busy    = (st_q != ST_IDLE);
  assign sclk    = (st_q == ST_SHIFT) ? (half_q ^ cfg.cpol ^ cfg.cpha) : cfg.cpol;
  assign mosi    = (st_q == ST_SHIFT) && (ph_q != PH_RX) && tx_bit;
  assign phase   = ph_q;
  assign bit_idx = bit_q;
  assign rx_we   = step && !half_q && (ph_q == PH_RX) && (bit_q < CNT_W'(BUF_BITS));
  assign rx_addr = {bit_q[BIDX_W-1:3], cfg.lsb ? bit_q[2:0] : ~bit_q[2:0]};
  assign rx_bit  = miso;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start) |=> busy); // R2

  AST_EMPTY_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && !has_work) |-> ##2 !busy); // R11

  AST_PHASE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT && $past(st_q) == ST_SHIFT && ph_q != $past(ph_q)) |->
      (ph_q > $past(ph_q))); // R3

  AST_BIT_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT) |-> (bit_q < plen)); // R5
endmodule

// File: rtl/spi_hd_master.sv
`timescale 1ns/1ps
module spi_hd_master
  import spi_hd_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  logic                  busy, start, rx_we, rx_bit, tx_bit;
  logic [BIDX_W-1:0]     rx_addr;
  logic [WORD_W-1:0]     cmd_word;
  logic [BUF_BITS-1:0]   data_buf;
  logic [NUM_CS-1:0]     cs_sel;
  logic [CNT_W-1:0]      bit_idx;
  logic [CMD_CNT_W-1:0]  cmd_len;
  cfg_t                  cfg;
  lens_t                 lens;
  phase_e                phase;

  spi_hd_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .rx_we     (rx_we),
    .rx_addr   (rx_addr),
    .rx_bit    (rx_bit),
    .start_o   (start),
    .cmd_word  (cmd_word),
    .data_buf  (data_buf),
    .cfg       (cfg),
    .lens      (lens),
    .cs_sel    (cs_sel)
  );

  spi_hd_txsel u_txsel (
    .cmd_word (cmd_word),
    .data_buf (data_buf),
    .phase    (phase),
    .bit_idx  (bit_idx),
    .cmd_len  (cmd_len),
    .lsb      (cfg.lsb),
    .tx_bit   (tx_bit)
  );

  spi_hd_engine u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cfg     (cfg),
    .lens    (lens),
    .tx_bit  (tx_bit),
    .miso    (spi_miso),
    .busy    (busy),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .phase   (phase),
    .bit_idx (bit_idx),
    .cmd_len (cmd_len),
    .rx_we   (rx_we),
    .rx_addr (rx_addr),
    .rx_bit  (rx_bit)
  );

  assign spi_cs_n = ~cs_sel;

  AST_SCLK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == cfg.cpol)); // R8
endmodule

// File: tb/tb_spi_hd_master.sv
`timescale 1ns/1ps
module tb_spi_hd_master;
  localparam int NCS = 4;
  localparam logic [5:0] A_CTRL = 6'h00, A_CMD = 6'h04, A_D0 = 6'h08,
                         A_CFG = 6'h28, A_LEN = 6'h2C, A_CS = 6'h38;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            bus_wr = 1'b0;
  logic [5:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            sclk, mosi;
  logic            miso = 1'b0;
  logic [NCS-1:0]  cs_n;

  spi_hd_master #(.NUM_CS(NCS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(sclk),
    .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // Scoreboard state: expected MOSI bytes and device-model settings.
  logic [7:0] sb_q[$];
  logic [7:0] pat [0:39];
  int         tx_bits = 0, ratio_cur = 2, sl_cnt = 0;
  logic       m_lsb = 0, m_cpol = 0, m_cpha = 0;
  logic [7:0] acc = '0;
  realtime    last_t = 0;
  bit         per_checked = 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_miso();
    int r;
    logic [7:0] b;
    r = sl_cnt - tx_bits;
    if (r < 0) miso = 1'b0;
    else begin
      b = pat[r / 8];
      miso = m_lsb ? b[r % 8] : b[7 - (r % 8)];
    end
  endtask

  // Monitor: on each sampling edge take MOSI, compare bytes against the queue.
  always @(sclk) begin
    int k;
    logic [7:0] e;
    if (cs_n[0] == 1'b0 && sclk == ~(m_cpol ^ m_cpha)) begin
      if (sl_cnt >= 1 && !per_checked) begin
        check("R7 sclk period ns", 32'(int'($realtime - last_t)), 32'(ratio_cur * 5));
        per_checked = 1;
      end
      last_t = $realtime;
      if (sl_cnt < tx_bits) begin
        k = sl_cnt % 8;
        if (m_lsb) acc[k] = mosi; else acc[7-k] = mosi;
        if (k == 7) begin
          if (sb_q.size() == 0) check("R3 unexpected byte", {24'b0, acc}, 32'hFFFF_FFFF);
          else begin
            e = sb_q.pop_front();
            check("R4/R5/R9 mosi byte", {24'b0, acc}, {24'b0, e});
          end
        end
      end else begin
        check("R3 mosi low in receive", {31'b0, mosi}, 32'd0);
      end
      sl_cnt++;
      drive_miso();
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(A_CTRL, d);
      if (d[16] == 1'b0) return;
    end
    check("R2 busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic set_mode(input int div, input bit lsb, input bit cpol, input bit cpha);
    wr(A_CFG, (32'(div) << 16) | (32'(cpha) << 5) | (32'(cpol) << 4) | (32'(lsb) << 3));
    m_lsb = lsb; m_cpol = cpol; m_cpha = cpha; ratio_cur = div + 2;
  endtask

  task automatic arm(input int cmd_field, input int cmd_eff, input int txb, input int rxb);
    wr(A_LEN, (32'(cmd_field) << 24) | (32'(rxb) << 12) | 32'(txb));
    tx_bits = cmd_eff + txb; sl_cnt = 0; per_checked = 0;
    drive_miso();
    wr(A_CS, 32'h1);
  endtask

  task automatic go(input int cmd_field, input int cmd_eff, input int txb, input int rxb, input string tag);
    arm(cmd_field, cmd_eff, txb, rxb);
    wr(A_CTRL, 32'h100);
    wait_idle();
    check({tag, " R10 cs held after transfer"}, {28'b0, cs_n}, 32'hE);
    check({tag, " R3 total bits"}, 32'(sl_cnt), 32'(cmd_eff + txb + rxb));
    check({tag, " R3 queue drained"}, 32'(sb_q.size()), 32'd0);
    wr(A_CS, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] prev;
    for (int i = 0; i < 40; i++) pat[i] = 8'(i * 29 + 7);
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_CMD, d);  check("R1 cmd", d, 32'h0);
    rd(A_CFG, d);  check("R1 cfg", d, 32'h0);
    rd(A_LEN, d);  check("R1 len", d, 32'h0);
    rd(A_D0, d);   check("R1 data0", d, 32'h0);
    check("R1 cs_n", {28'b0, cs_n}, 32'hF);
    check("R1 sclk", {31'b0, sclk}, 32'd0);
    check("R1 mosi", {31'b0, mosi}, 32'd0);

    // R10 chip-select register
    wr(A_CS, 32'h5);
    check("R10 cs_n inverse", {28'b0, cs_n}, 32'hA);
    rd(A_CS, d); check("R10 cs readback", d, 32'h5);
    wr(A_CS, 32'h0);

    // R4/R5 mode 0 MSB: 3 command bytes, 4 transmit bytes, ratio 4
    set_mode(2, 0, 0, 0);
    wr(A_CMD, 32'h00AABBCC);
    wr(A_D0, 32'h44332211);
    sb_q.push_back(8'hAA); sb_q.push_back(8'hBB); sb_q.push_back(8'hCC);
    sb_q.push_back(8'h11); sb_q.push_back(8'h22); sb_q.push_back(8'h33); sb_q.push_back(8'h44);
    go(24, 24, 32, 0, "T3");

    // R6/R8 mode 3, odd ratio 5, 1 command byte then 3 receive bytes
    set_mode(3, 0, 1, 1);
    wr(A_D0, 32'hDEADBEEF);
    wr(A_CMD, 32'h0000009F);
    sb_q.push_back(8'h9F);
    go(8, 8, 0, 24, "T4");
    rd(A_D0, d); check("R6 receive packing, byte3 kept", d, {8'hDE, pat[2], pat[1], pat[0]});
    check("R8 sclk idles at CPOL=1", {31'b0, sclk}, 32'd1);

    // R9/R4 mode 1 LSB-first, command count 40 clamps to 32, 2 receive bytes
    rd(A_D0, prev);
    set_mode(0, 1, 0, 1);
    wr(A_CMD, 32'h01020304);
    sb_q.push_back(8'h01); sb_q.push_back(8'h02); sb_q.push_back(8'h03); sb_q.push_back(8'h04);
    go(40, 32, 0, 16, "T5");
    rd(A_D0, d); check("R9 lsb-first receive", d, {prev[31:16], pat[1], pat[0]});

    // R8/R5 mode 2, ratio 7, transmit only
    set_mode(5, 0, 1, 0);
    wr(A_D0, 32'h0000BEEF);
    sb_q.push_back(8'hEF); sb_q.push_back(8'hBE);
    go(0, 0, 16, 0, "T6");
    check("R8 sclk idles at CPOL=1 mode2", {31'b0, sclk}, 32'd1);

    // R11 empty transaction
    set_mode(0, 0, 0, 0);
    wr(A_LEN, 32'h0);
    wr(A_CTRL, 32'h100);
    bus_addr = A_CTRL; #1;
    check("R11 busy one cycle after start", {31'b0, bus_rdata[16]}, 32'd1);
    @(negedge clk); #1;
    check("R11 busy dropped two cycles after start", {31'b0, bus_rdata[16]}, 32'd0);

    // R2/R12 start and register writes while busy
    set_mode(10, 0, 0, 0);
    wr(A_CMD, 32'h3C);
    sb_q.push_back(8'h3C);
    arm(8, 8, 0, 32);
    wr(A_CTRL, 32'h100);
    rd(A_CTRL, d); check("R2 busy after start", {31'b0, d[16]}, 32'd1);
    wr(A_CMD, 32'h55);
    wr(A_D0, 32'h12345678);
    wr(A_CTRL, 32'h100);
    wait_idle();
    repeat (30) @(negedge clk);
    check("R2 second start ignored", 32'(sl_cnt), 32'd40);
    rd(A_CMD, d); check("R12 cmd write while busy ignored", d, 32'h3C);
    rd(A_D0, d);  check("R12/R6 data write while busy ignored", d, {pat[3], pat[2], pat[1], pat[0]});
    wr(A_CS, 32'h0);

    // R6 receive longer than the buffer: 264 bits, first 256 kept
    set_mode(0, 0, 0, 0);
    go(0, 0, 0, 264, "T9");
    for (int w = 0; w < 8; w++) begin
      rd(A_D0 + 6'(4 * w), d);
      check("R6 overflow words", d, {pat[4*w+3], pat[4*w+2], pat[4*w+1], pat[4*w]});
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule